// File: doc/BRIEF.md
# Acknowledge-Polling Serial EEPROM Write Controller

This controller sits on the master side of a two-wire serial EEPROM link. It runs page writes and current-address reads, and it talks to a byte-level bit engine through a command/response handshake. A serial EEPROM starts an internal programming cycle after the STOP of a write. The device then takes several milliseconds and ignores the bus while it works. This block does not wait out a fixed worst-case delay. It probes the device instead: it sends a START and the slave address, then looks at the acknowledge bit. A high acknowledge bit means the device is still busy. The controller then closes the attempt with a STOP and tries again. A low acknowledge bit means the device is ready. The controller then carries on inside that same transaction, with no new START.

A write request carries a word address and a byte count. The data bytes are pulled from a valid/ready stream. A read request returns bytes from the device's current address pointer. The controller records that a programming cycle is pending after each successful write, and only then does the next request poll. While a write is pending, a timer counts cycles. If the device still refuses the address once the timer has reached its limit, the request ends with an error. The default limit is about 6 ms at 250 MHz. The error also clears the pending mark. Each request reports how many refused polls it took.

Top module: `ackpoll_writer`

## Requirements
- R1: After reset, `reqReady` is 1, `cmdValid` is 0 and `doneValid` is 0. No write is pending, and `reqReady`, `cmdValid` and `doneValid` are never high together.
- R2: A request accepted while no write is pending opens with exactly one START and the slave address, with no polling, and reports `pollCount` = 0.
- R3: A write sends START, then the address byte {DEV_ADDR, 0}, then the word address most significant byte first, then `reqLen`+1 data bytes in stream order, then STOP. It then marks a write as pending.
- R4: While a write is pending, a request opens with START plus the address byte. Each address answered with `rspNack` = 1 is followed by a STOP before the next START.
- R5: When a poll address is acknowledged (`rspNack` = 0), the controller carries on with no new START. For a write it sends the word address and data. For a read it reads data.
- R6: A read uses R/W = 1 (address byte {DEV_ADDR, 1}) and reads `reqLen`+1 bytes. `cmdAckLast` is 1 only on the final read command. Each byte appears on `rdData` with a one-cycle `rdValid`, and `rdLast` marks the final byte.
- R7: If a poll is refused once the pending timer has reached TIMEOUT_CYCLES, the controller sends STOP and then raises `doneValid` with `doneErr` = 1. The pending mark is cleared.
- R8: While `cmdValid` is 1 and `cmdReady` is 0, `cmdValid`, `cmdOp`, `cmdData` and `cmdAckLast` hold steady. Encoding of `cmdOp`: 0 START, 1 STOP, 2 write byte, 3 read byte.
- R9: `pollCount` equals the number of refused poll addresses in the most recent request.
- R10: If the address byte is refused when no write is pending, the controller sends STOP and ends the request with `doneErr` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Controller idle, request taken |
| reqRead | input | 1 | 1 = current-address read, 0 = write |
| reqWordAddr | input | ADDR_BYTES*8 | Word address for writes |
| reqLen | input | LEN_W | Byte count minus one |
| wrDataValid | input | 1 | Write data byte offered |
| wrDataReady | output | 1 | Write data byte taken |
| wrData | input | 8 | Write data byte |
| rdValid | output | 1 | Read byte strobe |
| rdData | output | 8 | Read byte |
| rdLast | output | 1 | Final read byte of the request |
| doneValid | output | 1 | Request finished (one cycle) |
| doneErr | output | 1 | Request finished with error |
| pollCount | output | POLL_W | Refused polls in last request |
| cmdValid | output | 1 | Command to bit engine offered |
| cmdReady | input | 1 | Bit engine takes command |
| cmdOp | output | 2 | 0 START, 1 STOP, 2 write byte, 3 read byte |
| cmdData | output | 8 | Byte to write |
| cmdAckLast | output | 1 | Master answers NACK after this read byte |
| rspValid | input | 1 | Bit engine response, one per command, at least one cycle after acceptance |
| rspNack | input | 1 | Acknowledge bit read high |
| rspData | input | 8 | Byte read |

## Verification
If the pending mark is lost, a request straight after a write goes out unpolled. The device then refuses the address, and `doneErr` appears within a few commands. If the mark sticks, `pollCount` and the START count stay the same, but a timeout shows up later. If the controller branches wrongly after a poll, it shows at the bit-engine port within one command. A missing STOP appears as a second START right after a refused address. An extra START appears where the word address byte should be. A byte-index fault changes the order of the word address bytes, or the count of data or read bytes. The loopback device model exposes either fault when the data is read back, or through `rdLast` and `cmdAckLast` on the same cycle.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;

  typedef enum logic [1:0] {
    BE_START = 2'd0,
    BE_STOP  = 2'd1,
    BE_WRITE = 2'd2,
    BE_READ  = 2'd3
  } beOp_e;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_SLAVE = 2'd1,
    SEL_WORD  = 2'd2,
    SEL_WDATA = 2'd3
  } byteSel_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_BUS_START,
    ST_WRITE_ADDR,
    ST_WRITE_WORD,
    ST_WRITE_DATA,
    ST_READ_DATA,
    ST_STOP,
    ST_POLL_START,
    ST_POLL_ADDR,
    ST_POLL_CHECK,
    ST_CONTINUE,
    ST_ERROR
  } state_e;

  typedef enum logic [1:0] {
    AS_POLL = 2'd0,
    AS_DONE = 2'd1,
    AS_ERR  = 2'd2
  } afterStop_e;

  typedef struct packed {
    logic     loadReq;
    logic     clrIdx;
    logic     incIdx;
    logic     incPoll;
    logic     setPending;
    logic     clrPending;
    byteSel_e sel;
  } dpStrobe_t;

endpackage

// File: rtl/ackpoll_datapath.sv
module ackpoll_datapath
  import ackpoll_pkg::*;
#(
  parameter int          ADDR_BYTES     = 2,
  parameter int          LEN_W          = 4,
  parameter logic [6:0]  DEV_ADDR       = 7'h50,
  parameter int          TIMEOUT_CYCLES = 1_500_000,
  parameter int          POLL_W         = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               strobe,
  input  logic                    reqRead,
  input  logic [ADDR_BYTES*8-1:0] reqWordAddr,
  input  logic [LEN_W-1:0]        reqLen,
  input  logic [7:0]              wrData,
  output logic                    opRead,
  output logic                    pending,
  output logic                    timeoutHit,
  output logic                    wordLast,
  output logic                    dataLast,
  output logic [7:0]              cmdData,
  output logic [POLL_W-1:0]       pollCount
);

  localparam int AW     = ADDR_BYTES * 8;
  localparam int WIDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int IDX_W  = (LEN_W > WIDX_W) ? LEN_W : WIDX_W;
  localparam int TMR_W  = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LIMIT = TMR_W'(TIMEOUT_CYCLES);

  logic              opReg;
  logic [AW-1:0]     wordReg;
  logic [LEN_W-1:0]  lenReg;
  logic [IDX_W-1:0]  byteIdx;
  logic [POLL_W-1:0] pollReg;
  logic              pendReg;
  logic [TMR_W-1:0]  busyTimer;
  logic [7:0]        wordByte;

  // request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg   <= 1'b0;
      wordReg <= '0;
      lenReg  <= '0;
    end else if (strobe.loadReq) begin
      opReg   <= reqRead;
      wordReg <= reqWordAddr;
      lenReg  <= reqLen;
    end
  end

  // byte index shared by word-address and data phases
  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteIdx <= '0;
    end else if (strobe.loadReq || strobe.clrIdx) begin
      byteIdx <= '0;
    end else if (strobe.incIdx) begin
      byteIdx <= byteIdx + 1'b1;
    end
  end

  // refused-poll counter, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pollReg <= '0;
    end else if (strobe.loadReq) begin
      pollReg <= '0;
    end else if (strobe.incPoll && (pollReg != {POLL_W{1'b1}})) begin
      pollReg <= pollReg + 1'b1;
    end
  end

  // pending write cycle and its timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendReg   <= 1'b0;
      busyTimer <= '0;
    end else begin
      if (strobe.setPending) begin
        pendReg   <= 1'b1;
        busyTimer <= '0;
      end else begin
        if (strobe.clrPending) begin
          pendReg <= 1'b0;
        end
        if (pendReg && (busyTimer < TMR_LIMIT)) begin
          busyTimer <= busyTimer + 1'b1;
        end
      end
    end
  end

  generate
    if (ADDR_BYTES == 1) begin : g_oneByte
      assign wordByte = wordReg[7:0];
    end else begin : g_multiByte
      logic [AW-1:0] shifted;
      assign shifted  = wordReg << {byteIdx, 3'b000};
      assign wordByte = shifted[AW-1 -: 8];
    end
  endgenerate

  always_comb begin
    unique case (strobe.sel)
      SEL_SLAVE: cmdData = {DEV_ADDR, opReg};
      SEL_WORD:  cmdData = wordByte;
      SEL_WDATA: cmdData = wrData;
      default:   cmdData = 8'h00;
    endcase
  end

  assign opRead     = opReg;
  assign pending    = pendReg;
  assign timeoutHit = (busyTimer >= TMR_LIMIT);
  assign wordLast   = (byteIdx == IDX_W'(ADDR_BYTES - 1));
  assign dataLast   = (byteIdx == IDX_W'(lenReg));
  assign pollCount  = pollReg;

  // timer never runs past its limit
  p_timer_cap_r7: assert property (@(posedge clk) disable iff (!rstN)
    busyTimer <= TMR_LIMIT);

  // a refused poll is only counted while a write cycle is pending
  p_poll_needs_pending_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.incPoll |-> pendReg);

  // a new request always starts its index and poll count from zero
  p_load_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadReq |=> (pollReg == '0) && (byteIdx == '0));

endmodule

// File: rtl/ackpoll_control.sv
module ackpoll_control
  import ackpoll_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  input  logic      opRead,
  input  logic      pending,
  input  logic      timeoutHit,
  input  logic      wordLast,
  input  logic      dataLast,
  input  logic      wrDataValid,
  output logic      wrDataReady,
  output logic      cmdValid,
  input  logic      cmdReady,
  output beOp_e     cmdOp,
  output logic      cmdAckLast,
  input  logic      rspValid,
  input  logic      rspNack,
  output logic      rdValid,
  output logic      rdLast,
  output logic      doneValid,
  output logic      doneErr,
  output dpStrobe_t strobe
);

  state_e     state, nextState;
  afterStop_e afterStop, nextAfter;
  logic       waitRsp;
  logic       nackReg;
  logic       stopOwed;
  logic       wantCmd;
  logic       rspDone;

  assign rspDone = waitRsp && rspValid;

  always_comb begin
    nextState   = state;
    nextAfter   = afterStop;
    strobe      = '0;
    strobe.sel  = SEL_NONE;
    reqReady    = 1'b0;
    wantCmd     = 1'b0;
    cmdOp       = BE_START;
    cmdAckLast  = 1'b0;
    rdValid     = 1'b0;
    rdLast      = 1'b0;
    doneValid   = 1'b0;
    doneErr     = 1'b0;

    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.loadReq = 1'b1;
          nextState      = pending ? ST_POLL_START : ST_BUS_START;
        end
      end

      ST_BUS_START, ST_POLL_START: begin
        wantCmd = 1'b1;
        cmdOp   = BE_START;
        if (rspDone) begin
          nextState = (state == ST_BUS_START) ? ST_WRITE_ADDR : ST_POLL_ADDR;
        end
      end

      ST_WRITE_ADDR: begin
        wantCmd    = 1'b1;
        cmdOp      = BE_WRITE;
        strobe.sel = SEL_SLAVE;
        if (rspDone) begin
          if (rspNack) begin
            nextState = ST_STOP;
            nextAfter = AS_ERR;
          end else begin
            nextState = ST_CONTINUE;
          end
        end
      end

      ST_POLL_ADDR: begin
        wantCmd    = 1'b1;
        cmdOp      = BE_WRITE;
        strobe.sel = SEL_SLAVE;
        if (rspDone) begin
          nextState = ST_POLL_CHECK;
        end
      end

      ST_POLL_CHECK: begin
        if (!nackReg) begin
          strobe.clrPending = 1'b1;
          nextState         = ST_CONTINUE;
        end else begin
          strobe.incPoll = 1'b1;
          nextAfter      = timeoutHit ? AS_ERR : AS_POLL;
          nextState      = ST_STOP;
        end
      end

      ST_CONTINUE: begin
        strobe.clrIdx = 1'b1;
        nextState     = opRead ? ST_READ_DATA : ST_WRITE_WORD;
      end

      ST_WRITE_WORD: begin
        wantCmd    = 1'b1;
        cmdOp      = BE_WRITE;
        strobe.sel = SEL_WORD;
        if (rspDone) begin
          if (rspNack) begin
            nextState = ST_STOP;
            nextAfter = AS_ERR;
          end else if (wordLast) begin
            strobe.clrIdx = 1'b1;
            nextState     = ST_WRITE_DATA;
          end else begin
            strobe.incIdx = 1'b1;
          end
        end
      end

      ST_WRITE_DATA: begin
        wantCmd    = wrDataValid;
        cmdOp      = BE_WRITE;
        strobe.sel = SEL_WDATA;
        if (rspDone) begin
          if (rspNack) begin
            nextState = ST_STOP;
            nextAfter = AS_ERR;
          end else if (dataLast) begin
            nextState = ST_STOP;
            nextAfter = AS_DONE;
          end else begin
            strobe.incIdx = 1'b1;
          end
        end
      end

      ST_READ_DATA: begin
        wantCmd    = 1'b1;
        cmdOp      = BE_READ;
        cmdAckLast = dataLast;
        if (rspDone) begin
          rdValid = 1'b1;
          rdLast  = dataLast;
          if (dataLast) begin
            nextState = ST_STOP;
            nextAfter = AS_DONE;
          end else begin
            strobe.incIdx = 1'b1;
          end
        end
      end

      ST_STOP: begin
        wantCmd = 1'b1;
        cmdOp   = BE_STOP;
        if (rspDone) begin
          unique case (afterStop)
            AS_POLL: nextState = ST_POLL_START;
            AS_DONE: begin
              doneValid         = 1'b1;
              strobe.setPending = !opRead;
              nextState         = ST_IDLE;
            end
            default: nextState = ST_ERROR;
          endcase
        end
      end

      ST_ERROR: begin
        doneValid         = 1'b1;
        doneErr           = 1'b1;
        strobe.clrPending = 1'b1;
        nextState         = ST_IDLE;
      end

      default: nextState = ST_IDLE;
    endcase
  end

  assign cmdValid    = wantCmd && !waitRsp;
  assign wrDataReady = (state == ST_WRITE_DATA) && cmdValid && cmdReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      afterStop <= AS_DONE;
      waitRsp   <= 1'b0;
      nackReg   <= 1'b0;
      stopOwed  <= 1'b0;
    end else begin
      state     <= nextState;
      afterStop <= nextAfter;
      if (cmdValid && cmdReady) begin
        waitRsp <= 1'b1;
      end else if (rspDone) begin
        waitRsp <= 1'b0;
      end
      if ((state == ST_POLL_ADDR) && rspDone) begin
        nackReg <= rspNack;
      end
      if ((state == ST_POLL_CHECK) && nackReg) begin
        stopOwed <= 1'b1;
      end else if (cmdValid && cmdReady && (cmdOp == BE_STOP)) begin
        stopOwed <= 1'b0;
      end
    end
  end

  // a command waiting for the engine keeps its content
  p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdOp) && $stable(cmdAckLast));

  // after a refused poll, the next command offered is a STOP
  p_stop_before_repoll_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && stopOwed |-> cmdOp == BE_STOP);

  // request intake, bus activity and completion never overlap
  p_exclusive_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({reqReady, cmdValid, doneValid}));

  // an error is always reported as a completion
  p_err_is_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneErr |-> doneValid);

  // read strobes only while a response is being consumed
  p_read_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> rspValid && !cmdValid);

endmodule

// File: rtl/ackpoll_writer.sv
module ackpoll_writer
  import ackpoll_pkg::*;
#(
  parameter int          ADDR_BYTES     = 2,
  parameter int          LEN_W          = 4,
  parameter logic [6:0]  DEV_ADDR       = 7'h50,
  parameter int          TIMEOUT_CYCLES = 1_500_000,
  parameter int          POLL_W         = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic                    reqRead,
  input  logic [ADDR_BYTES*8-1:0] reqWordAddr,
  input  logic [LEN_W-1:0]        reqLen,
  input  logic                    wrDataValid,
  output logic                    wrDataReady,
  input  logic [7:0]              wrData,
  output logic                    rdValid,
  output logic [7:0]              rdData,
  output logic                    rdLast,
  output logic                    doneValid,
  output logic                    doneErr,
  output logic [POLL_W-1:0]       pollCount,
  output logic                    cmdValid,
  input  logic                    cmdReady,
  output logic [1:0]              cmdOp,
  output logic [7:0]              cmdData,
  output logic                    cmdAckLast,
  input  logic                    rspValid,
  input  logic                    rspNack,
  input  logic [7:0]              rspData
);

  dpStrobe_t strobe;
  beOp_e     cmdOpE;
  logic      opRead, pending, timeoutHit, wordLast, dataLast;

  ackpoll_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .opRead     (opRead),
    .pending    (pending),
    .timeoutHit (timeoutHit),
    .wordLast   (wordLast),
    .dataLast   (dataLast),
    .wrDataValid(wrDataValid),
    .wrDataReady(wrDataReady),
    .cmdValid   (cmdValid),
    .cmdReady   (cmdReady),
    .cmdOp      (cmdOpE),
    .cmdAckLast (cmdAckLast),
    .rspValid   (rspValid),
    .rspNack    (rspNack),
    .rdValid    (rdValid),
    .rdLast     (rdLast),
    .doneValid  (doneValid),
    .doneErr    (doneErr),
    .strobe     (strobe)
  );

  ackpoll_datapath #(
    .ADDR_BYTES    (ADDR_BYTES),
    .LEN_W         (LEN_W),
    .DEV_ADDR      (DEV_ADDR),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .POLL_W        (POLL_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqRead    (reqRead),
    .reqWordAddr(reqWordAddr),
    .reqLen     (reqLen),
    .wrData     (wrData),
    .opRead     (opRead),
    .pending    (pending),
    .timeoutHit (timeoutHit),
    .wordLast   (wordLast),
    .dataLast   (dataLast),
    .cmdData    (cmdData),
    .pollCount  (pollCount)
  );

  assign cmdOp  = cmdOpE;
  assign rdData = rspData;

  // write data on the engine port holds while the engine stalls
  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> $stable(cmdData));

endmodule

// File: tb/ackpoll_writer_bench.sv
`timescale 1ns/100ps
module ackpoll_writer_bench;

  localparam int         AB      = 2;
  localparam int         LW      = 4;
  localparam logic [6:0] DEV     = 7'h50;
  localparam int         TMO     = 2000;
  localparam int         PW      = 8;
  localparam int PH_IDLE = 0, PH_ADDR = 1, PH_WORD = 2, PH_DATA = 3, PH_READ = 4, PH_IGN = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0, reqReady, reqRead = 1'b0;
  logic [15:0]   reqWordAddr = '0;
  logic [LW-1:0] reqLen = '0;
  logic          wrDataValid = 1'b0, wrDataReady;
  logic [7:0]    wrData = '0;
  logic          rdValid, rdLast, doneValid, doneErr;
  logic [7:0]    rdData;
  logic [PW-1:0] pollCount;
  logic          cmdValid, cmdReady = 1'b0, cmdAckLast;
  logic [1:0]    cmdOp;
  logic [7:0]    cmdData;
  logic          rspValid = 1'b0, rspNack = 1'b0;
  logic [7:0]    rspData = '0;

  always #2 clk = ~clk;

  ackpoll_writer #(.ADDR_BYTES(AB), .LEN_W(LW), .DEV_ADDR(DEV),
                   .TIMEOUT_CYCLES(TMO), .POLL_W(PW)) u_ackpoll_writer (.*);

  int checks = 0, failures = 0;

  // device model state
  logic [7:0]  devMem [256];
  logic [7:0]  expMem [256];
  logic [15:0] devPtr = '0, expPtr = '0, seenWord = '0;
  int  phase = PH_IDLE, wordCnt = 0, wroteBytes = 0, busyLeft = 0, busyCfg = 100;
  bit  needStop = 0;
  int  violStop = 0, badAddr = 0, oddCnt = 0, ackBad = 0, holdBad = 0;
  int  nacksOp = 0, startsOp = 0, readIdx = 0, curLen = 0, lastRw = 0;
  bit  outstanding = 0, pNack = 0;
  logic [7:0] pData = '0;
  int  delay = 0;
  bit  holdPend = 0;
  logic [1:0] holdOp; logic [7:0] holdData;
  logic [7:0] wq [16];
  int  wqLen = 0, wqIdx = 0;
  logic [7:0] rdBuf [16];
  int  rdCnt = 0, rdLastBad = 0;
  bit  doneSeen = 0, doneErrSeen = 0;
  bit  expPending = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelCmd();
    pNack = 1'b0;
    pData = 8'h00;
    case (cmdOp)
      2'd0: begin
        if (needStop) violStop++;
        phase = PH_ADDR;
        startsOp++;
      end
      2'd1: begin
        if (wroteBytes > 0) busyLeft = busyCfg;
        wroteBytes = 0;
        needStop   = 0;
        phase      = PH_IDLE;
      end
      2'd2: begin
        case (phase)
          PH_ADDR: begin
            if (cmdData[7:1] != DEV) badAddr++;
            lastRw = int'(cmdData[0]);
            if (busyLeft > 0) begin
              pNack = 1'b1; nacksOp++; needStop = 1; phase = PH_IGN;
            end else begin
              phase = cmdData[0] ? PH_READ : PH_WORD;
              wordCnt = 0;
            end
          end
          PH_WORD: begin
            devPtr = {devPtr[7:0], cmdData};
            wordCnt++;
            if (wordCnt == AB) begin phase = PH_DATA; seenWord = devPtr; end
          end
          PH_DATA: begin
            devMem[devPtr[7:0]] = cmdData;
            devPtr = devPtr + 16'd1;
            wroteBytes++;
          end
          default: begin pNack = 1'b1; oddCnt++; end
        endcase
      end
      default: begin
        if (phase == PH_READ) begin
          pData = devMem[devPtr[7:0]];
          devPtr = devPtr + 16'd1;
          if (cmdAckLast != (readIdx == curLen)) ackBad++;
          readIdx++;
        end else begin
          oddCnt++;
        end
      end
    endcase
  endtask

  // bit engine + device model, data feeder and monitor, all at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (busyLeft > 0) busyLeft--;
      if (rspValid) rspValid = 1'b0;
      if (outstanding) begin
        if (delay == 0) begin
          rspValid = 1'b1; rspNack = pNack; rspData = pData; outstanding = 0;
        end else begin
          delay--;
        end
      end
      cmdReady = !outstanding && ($urandom % 4 != 0);
      wrDataValid = (wqIdx < wqLen);
      wrData = wq[wqIdx % 16];
      #0.2;
      if (holdPend && !(cmdValid && cmdOp == holdOp && cmdData == holdData)) holdBad++;
      holdPend = cmdValid && !cmdReady;
      holdOp = cmdOp; holdData = cmdData;
      if (cmdValid && cmdReady) begin
        modelCmd();
        outstanding = 1;
        delay = $urandom % 3;
      end
      if (wrDataReady) wqIdx++;
      if (rdValid) begin
        rdBuf[rdCnt % 16] = rdData;
        if (rdLast != (rdCnt == curLen)) rdLastBad++;
        rdCnt++;
      end
      if (doneValid) begin doneSeen = 1; doneErrSeen = doneErr; end
    end
  end

  task automatic runOp(input bit rd, input logic [15:0] addr, input int len, output bit err);
    int n;
    nacksOp = 0; startsOp = 0; readIdx = 0; curLen = len; rdCnt = 0;
    rdLastBad = 0; doneSeen = 0; doneErrSeen = 0; wqIdx = 0;
    if (!rd) begin
      for (int i = 0; i <= len; i++) wq[i] = 8'($urandom);
      wqLen = len + 1;
    end else begin
      wqLen = 0;
    end
    @(negedge clk); #0.4;
    reqValid = 1'b1; reqRead = rd; reqWordAddr = addr; reqLen = LW'(len);
    while (!reqReady) begin @(negedge clk); #0.4; end
    @(negedge clk); #0.4;
    reqValid = 1'b0;
    n = 0;
    while (!doneSeen && n < 30000) begin @(negedge clk); #0.4; n++; end
    check(doneSeen, "R3 request completes", int'(doneSeen), 1);
    wqLen = 0;
    err = doneErrSeen;
  endtask

  task automatic doWrite(input logic [15:0] addr, input int len);
    bit err;
    bit wasPending = expPending;
    runOp(1'b0, addr, len, err);
    check(!err, "R3 write no error", int'(err), 0);
    check(lastRw == 0, "R3 address R/W bit", lastRw, 0);
    check(seenWord == addr, "R3 word address order", int'(seenWord), int'(addr));
    for (int i = 0; i <= len; i++) begin
      logic [15:0] a = addr + 16'(i);
      expMem[a[7:0]] = wq[i];
      check(devMem[a[7:0]] == expMem[a[7:0]], "R3 data byte", int'(devMem[a[7:0]]), int'(expMem[a[7:0]]));
    end
    if (!wasPending) begin
      check(startsOp == 1 && nacksOp == 0, "R2 unpolled start count", startsOp, 1);
      check(pollCount == 0, "R2 pollCount zero", int'(pollCount), 0);
    end else begin
      check(startsOp == nacksOp + 1, "R5 single start after ack", startsOp, nacksOp + 1);
      check(int'(pollCount) == nacksOp, "R9 pollCount", int'(pollCount), nacksOp);
    end
    check(violStop == 0, "R4 stop between polls", violStop, 0);
    expPtr = addr + 16'(len + 1);
    expPending = 1;
  endtask

  task automatic doRead(input int len);
    bit err;
    bit wasPending = expPending;
    runOp(1'b1, 16'h0, len, err);
    check(!err, "R6 read no error", int'(err), 0);
    check(lastRw == 1, "R6 address R/W bit", lastRw, 1);
    check(rdCnt == len + 1, "R6 read byte count", rdCnt, len + 1);
    for (int i = 0; i <= len; i++) begin
      logic [15:0] a = expPtr + 16'(i);
      check(rdBuf[i] == expMem[a[7:0]], "R6 read data", int'(rdBuf[i]), int'(expMem[a[7:0]]));
    end
    check(rdLastBad == 0 && ackBad == 0, "R6 last byte flags", rdLastBad + ackBad, 0);
    if (wasPending) begin
      check(startsOp == nacksOp + 1, "R5 read continues after ack", startsOp, nacksOp + 1);
      check(int'(pollCount) == nacksOp, "R9 read pollCount", int'(pollCount), nacksOp);
    end else begin
      check(startsOp == 1, "R2 read unpolled", startsOp, 1);
    end
    expPtr = expPtr + 16'(len + 1);
    expPending = 0;
  endtask

  initial begin
    bit err;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      devMem[i] = 8'(i) ^ 8'h5A;
      expMem[i] = 8'(i) ^ 8'h5A;
    end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #0.4;
    check(reqReady === 1'b1, "R1 reqReady after reset", int'(reqReady), 1);
    check(cmdValid === 1'b0, "R1 cmdValid after reset", int'(cmdValid), 0);
    check(doneValid === 1'b0, "R1 doneValid after reset", int'(doneValid), 0);

    // directed: first write skips polling, second write polls
    busyCfg = 300;
    doWrite(16'h1234, 3);
    busyCfg = 150;
    doWrite(16'h1238, 0);
    check(nacksOp > 0, "R4 busy device refused", nacksOp, 1);
    doRead(0);
    busyCfg = 80;
    doWrite(16'h00FE, 15);
    doRead(5);

    // constrained random mix
    for (int k = 0; k < 30; k++) begin
      int gap = $urandom % 40;
      repeat (gap) @(negedge clk);
      busyCfg = 20 + ($urandom % 380);
      if ($urandom % 10 < 6) doWrite(16'($urandom), $urandom % 16);
      else doRead($urandom % 16);
    end

    // timeout: device stays busy past the limit
    busyCfg = 6000;
    doWrite(16'h4000, 1);
    runOp(1'b0, 16'h4100, 1, err);
    check(err, "R7 timeout reports error", int'(err), 1);
    check(phase == PH_IDLE && !needStop, "R7 stop before error", phase, PH_IDLE);
    check(int'(pollCount) == nacksOp && nacksOp > 0, "R9 polls before timeout", int'(pollCount), nacksOp);
    expPending = 0;

    // pending cleared: unpolled address refused by busy device
    runOp(1'b0, 16'h4200, 0, err);
    check(err, "R10 refused address error", int'(err), 1);
    check(startsOp == 1 && pollCount == 0, "R10 no polling after error", startsOp, 1);
    check(phase == PH_IDLE, "R10 stop issued", phase, PH_IDLE);
    while (busyLeft > 0) @(negedge clk);
    busyCfg = 50;
    doWrite(16'h4300, 2);
    doRead(2);

    check(holdBad == 0, "R8 command held while stalled", holdBad, 0);
    check(badAddr == 0 && oddCnt == 0, "R3 protocol well formed", badAddr + oddCnt, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule